// File: doc/BRIEF.md
# Bank Write Transaction Sequencer

This block sits on the controller side of a packet-based DRAM and runs one write transaction on one bank. It accepts a request that names a device, a bank, a row and a list of up to eight columns, each column with a byte-mask word and a flag that says whether the mask is sent. It then issues single-cycle command pulses in order. An activate goes out first on the row channel. Column writes and their retire commands go out on the column channel, and a mask pulse travels with a retire. A precharge goes out last on the row channel. The block also raises a data-launch strobe for each column so that the data path can start the matching write data.

Every spacing comes from a run-time register given in cycles. The block copies all of these registers when it accepts a request, and any value of zero counts as one. One elapsed-cycle counter, which starts at the activate, drives all events. A request uses a valid/ready handshake. Ready is raised exactly one cycle before the earliest cycle in which the next activate to this bank is legal. A request that waits during that cycle therefore activates with no idle gap. Between acceptance and that point the block holds `busy` high.

Top module: `bankWriteSeq`

## Requirements
- R1: During and after reset, `reqReady` is high, `busy` is low, and no command, mask or data strobe is asserted.
- R2: When a request is accepted (`reqValid` and `reqReady` high at a clock edge), `actValid` pulses in the next cycle with `actRow`, `cmdDev` and `cmdBank` equal to the request. `busy` is high from that cycle on. Below, cycle 0 means the activate cycle and N is the effective column count.
- R3: Column write k (k = 0..N-1) pulses `wrValid` at cycle RCD + k*CC. `wrCol` then equals column field k of `reqColList` (bits k*COL_W upward).
- R4: The data-launch strobe `wdValid` for column k pulses at the write cycle plus CWD plus a fixed offset of one cycle, with `wdIndex` = k.
- R5: Retire k pulses `retValid` at write k's cycle plus RTR. `mskValid` pulses in that same cycle only if bit k of `reqMaskUse` is set, and `mskBits` then equals mask field k of `reqMaskList` (bits k*MASK_W upward).
- R6: `preValid` pulses exactly once, at P = max(RAS, last retire cycle + RTP).
- R7: `reqReady` is low from cycle 0 until cycle E-1 and high in cycle E-1. E is the largest of RC, P + RP, and the last data-launch cycle + 1. A request held valid while ready is low is not accepted and creates no activate.
- R8: A column count of 0 is run as 1, and a count above 8 is run as 8.
- R9: A timing register value of 0 behaves as 1.
- R10: The timing registers are captured at acceptance. Changes to them during a transaction have no effect on its schedule.
- R11: Writes, retires and precharge occur only while the row is open, meaning after an activate and no later than its precharge. An activate never occurs while a row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted at this edge if valid |
| reqDev | input | DEV_W | Device address |
| reqBank | input | BANK_W | Bank address |
| reqRow | input | ROW_W | Row address |
| reqColCount | input | clog2(MAX_COLS+1) | Number of columns (clamped to 1..MAX_COLS) |
| reqColList | input | MAX_COLS*COL_W | Column addresses, entry k at bits k*COL_W |
| reqMaskUse | input | MAX_COLS | Bit k: send a mask with retire k |
| reqMaskList | input | MAX_COLS*MASK_W | Byte masks, entry k at bits k*MASK_W |
| cfgRcd | input | TW | Activate to first write |
| cfgCwd | input | TW | Write to data launch (before the fixed offset) |
| cfgCc | input | TW | Write to write |
| cfgRtr | input | TW | Write to its retire |
| cfgRas | input | TW | Activate to precharge |
| cfgRtp | input | TW | Last retire to precharge |
| cfgRc | input | TW | Activate to next activate |
| cfgRp | input | TW | Precharge to next activate |
| busy | output | 1 | Transaction or trailing spacing in progress |
| cmdDev | output | DEV_W | Device of the current transaction |
| cmdBank | output | BANK_W | Bank of the current transaction |
| actValid | output | 1 | Activate pulse |
| actRow | output | ROW_W | Row of the activate |
| wrValid | output | 1 | Column write pulse |
| wrCol | output | COL_W | Column of the write |
| retValid | output | 1 | Retire pulse |
| mskValid | output | 1 | Mask pulse that goes with the retire |
| mskBits | output | MASK_W | Byte mask |
| wdValid | output | 1 | Write-data launch strobe |
| wdIndex | output | clog2(MAX_COLS) | Column index of the data to launch |
| preValid | output | 1 | Precharge pulse |

## Verification
On every cycle the assertions check the ordering properties that need no arithmetic. A mask never appears without its retire. An accepted request always produces an activate in the next cycle, and an activate only ever follows an acceptance. Column commands and the precharge stay inside the open-row window. The precharge never comes earlier than the captured RAS after the activate. The exact cycle of every write, data launch, retire and precharge, and the cycle in which ready returns, come from max-of-sums formulas over eight registers. Only the bench's sweeps over column counts and timing sets can show that these exact cycles are right. The same holds for column and mask selection, count clamping, the zero-as-one rule and the capture of the registers at acceptance.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic actGo;
    logic wrGo;
    logic retGo;
    logic datGo;
    logic preGo;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic actDue;
    logic wrDue;
    logic retDue;
    logic datDue;
    logic preDue;
    logic spacingMet;
  } seqStatus_t;

endpackage

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  seqStatus_t st,
  output logic       reqReady,
  output seqStrobe_t sb
);

  seqState_e state, stateNx;
  logic run;
  logic accept;

  always_comb begin
    run      = (state == ST_RUN);
    reqReady = !run || st.spacingMet;
    accept   = reqValid && reqReady;

    sb.load  = accept;
    sb.actGo = run && st.actDue;
    sb.wrGo  = run && st.wrDue;
    sb.retGo = run && st.retDue;
    sb.datGo = run && st.datDue;
    sb.preGo = run && st.preDue;

    stateNx = state;
    if (accept)                   stateNx = ST_RUN;
    else if (run && st.spacingMet) stateNx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

endmodule

// File: rtl/bws_datapath.sv
module bws_datapath
  import bws_pkg::*;
#(
  parameter int DEV_W    = 5,
  parameter int BANK_W   = 4,
  parameter int ROW_W    = 9,
  parameter int COL_W    = 6,
  parameter int MASK_W   = 16,
  parameter int MAX_COLS = 8,
  parameter int TW       = 8,
  parameter int DATA_OFS = 1
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  seqStrobe_t                            sb,
  input  logic [DEV_W-1:0]                      reqDev,
  input  logic [BANK_W-1:0]                     reqBank,
  input  logic [ROW_W-1:0]                      reqRow,
  input  logic [$clog2(MAX_COLS+1)-1:0]         reqColCount,
  input  logic [MAX_COLS*COL_W-1:0]             reqColList,
  input  logic [MAX_COLS-1:0]                   reqMaskUse,
  input  logic [MAX_COLS*MASK_W-1:0]            reqMaskList,
  input  logic [TW-1:0]                         cfgRcd,
  input  logic [TW-1:0]                         cfgCwd,
  input  logic [TW-1:0]                         cfgCc,
  input  logic [TW-1:0]                         cfgRtr,
  input  logic [TW-1:0]                         cfgRas,
  input  logic [TW-1:0]                         cfgRtp,
  input  logic [TW-1:0]                         cfgRc,
  input  logic [TW-1:0]                         cfgRp,
  output seqStatus_t                            st,
  output logic [DEV_W-1:0]                      cmdDev,
  output logic [BANK_W-1:0]                     cmdBank,
  output logic [ROW_W-1:0]                      actRow,
  output logic [COL_W-1:0]                      wrCol,
  output logic                                  retMaskUse,
  output logic [MASK_W-1:0]                     mskBits,
  output logic [((MAX_COLS>1)?$clog2(MAX_COLS):1)-1:0] wdIndex
);

  localparam int CNT_W = $clog2(MAX_COLS + 1);
  localparam int IDX_W = (MAX_COLS > 1) ? $clog2(MAX_COLS) : 1;
  localparam int TK_W  = TW + 4;

  function automatic logic [TK_W-1:0] eff(input logic [TW-1:0] v);
    return (v == '0) ? TK_W'(1) : TK_W'(v);
  endfunction

  logic [TK_W-1:0]   tick, nextWr, nextRet, nextDat, lastRet, preTick;
  logic [TK_W-1:0]   ccQ, rasQ, rtpQ, rcQ, rpQ;
  logic [CNT_W-1:0]  countQ, wrIdx, retIdx, datIdx;
  logic              preDone;
  logic [DEV_W-1:0]  devQ;
  logic [BANK_W-1:0] bankQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ  [MAX_COLS];
  logic [MASK_W-1:0] maskQ [MAX_COLS];
  logic [MAX_COLS-1:0] useQ;
  logic [CNT_W-1:0]  countIn;

  always_comb begin
    if (reqColCount == '0)                     countIn = CNT_W'(1);
    else if (reqColCount > CNT_W'(MAX_COLS))   countIn = CNT_W'(MAX_COLS);
    else                                       countIn = reqColCount;
  end

  // transaction context and per-column tables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devQ  <= '0;
      bankQ <= '0;
      rowQ  <= '0;
      useQ  <= '0;
      for (int i = 0; i < MAX_COLS; i++) begin
        colQ[i]  <= '0;
        maskQ[i] <= '0;
      end
    end else if (sb.load) begin
      devQ  <= reqDev;
      bankQ <= reqBank;
      rowQ  <= reqRow;
      useQ  <= reqMaskUse;
      for (int i = 0; i < MAX_COLS; i++) begin
        colQ[i]  <= reqColList[i*COL_W +: COL_W];
        maskQ[i] <= reqMaskList[i*MASK_W +: MASK_W];
      end
    end
  end

  // elapsed counter, event targets and captured spacings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tick    <= '0;
      nextWr  <= '0;
      nextRet <= '0;
      nextDat <= '0;
      lastRet <= '0;
      preTick <= '0;
      preDone <= 1'b0;
      countQ  <= CNT_W'(1);
      wrIdx   <= '0;
      retIdx  <= '0;
      datIdx  <= '0;
      ccQ     <= TK_W'(1);
      rasQ    <= TK_W'(1);
      rtpQ    <= TK_W'(1);
      rcQ     <= TK_W'(1);
      rpQ     <= TK_W'(1);
    end else if (sb.load) begin
      tick    <= '0;
      nextWr  <= eff(cfgRcd);
      nextRet <= eff(cfgRcd) + eff(cfgRtr);
      nextDat <= eff(cfgRcd) + eff(cfgCwd) + TK_W'(DATA_OFS);
      lastRet <= '0;
      preTick <= '0;
      preDone <= 1'b0;
      countQ  <= countIn;
      wrIdx   <= '0;
      retIdx  <= '0;
      datIdx  <= '0;
      ccQ     <= eff(cfgCc);
      rasQ    <= eff(cfgRas);
      rtpQ    <= eff(cfgRtp);
      rcQ     <= eff(cfgRc);
      rpQ     <= eff(cfgRp);
    end else begin
      if (tick != '1) tick <= tick + TK_W'(1);
      if (sb.wrGo) begin
        wrIdx  <= wrIdx + CNT_W'(1);
        nextWr <= nextWr + ccQ;
      end
      if (sb.retGo) begin
        retIdx  <= retIdx + CNT_W'(1);
        nextRet <= nextRet + ccQ;
        lastRet <= tick;
      end
      if (sb.datGo) begin
        datIdx  <= datIdx + CNT_W'(1);
        nextDat <= nextDat + ccQ;
      end
      if (sb.preGo) begin
        preDone <= 1'b1;
        preTick <= tick;
      end
    end
  end

  logic actDue, wrDue, retDue, datDue, preDue, datAll, spacingMet;
  logic [TK_W-1:0] preRef, tickNx;

  always_comb begin
    actDue = (tick == '0);
    wrDue  = (wrIdx  < countQ) && (tick == nextWr);
    retDue = (retIdx < countQ) && (tick == nextRet);
    datDue = (datIdx < countQ) && (tick == nextDat);
    preDue = !preDone && (retIdx == countQ) &&
             (tick >= rasQ) && (tick >= lastRet + rtpQ);
    // look one cycle ahead: ready now means an activate next cycle is legal
    datAll = (datIdx == countQ) || (datDue && (datIdx + CNT_W'(1) == countQ));
    preRef = preDone ? preTick : tick;
    tickNx = tick + TK_W'(1);
    spacingMet = (preDone || preDue) && datAll &&
                 (tickNx >= rcQ) && (tickNx >= preRef + rpQ);
  end

  assign st.actDue     = actDue;
  assign st.wrDue      = wrDue;
  assign st.retDue     = retDue;
  assign st.datDue     = datDue;
  assign st.preDue     = preDue;
  assign st.spacingMet = spacingMet;

  assign cmdDev     = devQ;
  assign cmdBank    = bankQ;
  assign actRow     = rowQ;
  assign wrCol      = colQ[wrIdx[IDX_W-1:0]];
  assign retMaskUse = useQ[retIdx[IDX_W-1:0]];
  assign mskBits    = maskQ[retIdx[IDX_W-1:0]];
  assign wdIndex    = datIdx[IDX_W-1:0];

endmodule

// File: rtl/bankWriteSeq.sv
module bankWriteSeq
  import bws_pkg::*;
#(
  parameter int DEV_W    = 5,
  parameter int BANK_W   = 4,
  parameter int ROW_W    = 9,
  parameter int COL_W    = 6,
  parameter int MASK_W   = 16,
  parameter int MAX_COLS = 8,
  parameter int TW       = 8,
  parameter int DATA_OFS = 1
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  output logic                                  reqReady,
  input  logic [DEV_W-1:0]                      reqDev,
  input  logic [BANK_W-1:0]                     reqBank,
  input  logic [ROW_W-1:0]                      reqRow,
  input  logic [$clog2(MAX_COLS+1)-1:0]         reqColCount,
  input  logic [MAX_COLS*COL_W-1:0]             reqColList,
  input  logic [MAX_COLS-1:0]                   reqMaskUse,
  input  logic [MAX_COLS*MASK_W-1:0]            reqMaskList,
  input  logic [TW-1:0]                         cfgRcd,
  input  logic [TW-1:0]                         cfgCwd,
  input  logic [TW-1:0]                         cfgCc,
  input  logic [TW-1:0]                         cfgRtr,
  input  logic [TW-1:0]                         cfgRas,
  input  logic [TW-1:0]                         cfgRtp,
  input  logic [TW-1:0]                         cfgRc,
  input  logic [TW-1:0]                         cfgRp,
  output logic                                  busy,
  output logic [DEV_W-1:0]                      cmdDev,
  output logic [BANK_W-1:0]                     cmdBank,
  output logic                                  actValid,
  output logic [ROW_W-1:0]                      actRow,
  output logic                                  wrValid,
  output logic [COL_W-1:0]                      wrCol,
  output logic                                  retValid,
  output logic                                  mskValid,
  output logic [MASK_W-1:0]                     mskBits,
  output logic                                  wdValid,
  output logic [((MAX_COLS>1)?$clog2(MAX_COLS):1)-1:0] wdIndex,
  output logic                                  preValid
);

  seqStrobe_t sb;
  seqStatus_t st;
  logic       retMaskUse;

  bws_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .st       (st),
    .reqReady (reqReady),
    .sb       (sb)
  );

  bws_datapath #(
    .DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .MASK_W(MASK_W), .MAX_COLS(MAX_COLS), .TW(TW), .DATA_OFS(DATA_OFS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .sb          (sb),
    .reqDev      (reqDev),
    .reqBank     (reqBank),
    .reqRow      (reqRow),
    .reqColCount (reqColCount),
    .reqColList  (reqColList),
    .reqMaskUse  (reqMaskUse),
    .reqMaskList (reqMaskList),
    .cfgRcd      (cfgRcd),
    .cfgCwd      (cfgCwd),
    .cfgCc       (cfgCc),
    .cfgRtr      (cfgRtr),
    .cfgRas      (cfgRas),
    .cfgRtp      (cfgRtp),
    .cfgRc       (cfgRc),
    .cfgRp       (cfgRp),
    .st          (st),
    .cmdDev      (cmdDev),
    .cmdBank     (cmdBank),
    .actRow      (actRow),
    .wrCol       (wrCol),
    .retMaskUse  (retMaskUse),
    .mskBits     (mskBits),
    .wdIndex     (wdIndex)
  );

  assign busy     = !reqReady;
  assign actValid = sb.actGo;
  assign wrValid  = sb.wrGo;
  assign retValid = sb.retGo;
  assign mskValid = sb.retGo && retMaskUse;
  assign wdValid  = sb.datGo;
  assign preValid = sb.preGo;

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          busy,
  input logic          actValid,
  input logic          wrValid,
  input logic          retValid,
  input logic          mskValid,
  input logic          preValid,
  input logic [TW-1:0] cfgRas
);

  localparam int TK_W = TW + 4;

  logic            rowOpen;
  logic [TK_W-1:0] sinceAct;
  logic [TK_W-1:0] rasHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOpen  <= 1'b0;
      sinceAct <= '0;
      rasHeld  <= TK_W'(1);
    end else begin
      if (actValid)      rowOpen <= 1'b1;
      else if (preValid) rowOpen <= 1'b0;
      if (actValid)             sinceAct <= TK_W'(1);
      else if (sinceAct != '1)  sinceAct <= sinceAct + TK_W'(1);
      if (reqValid && reqReady)
        rasHeld <= (cfgRas == '0) ? TK_W'(1) : TK_W'(cfgRas);
    end
  end

  assert_accept_to_act_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> actValid);

  assert_act_needs_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    actValid |-> $past(reqValid && reqReady));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  assert_mask_with_retire_R5: assert property (@(posedge clk) disable iff (!rstN)
    mskValid |-> retValid);

  assert_ras_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    preValid |-> (sinceAct >= rasHeld));

  assert_col_in_open_row_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || retValid) |-> rowOpen);

  assert_pre_in_open_row_R11: assert property (@(posedge clk) disable iff (!rstN)
    preValid |-> rowOpen);

  assert_act_on_closed_row_R11: assert property (@(posedge clk) disable iff (!rstN)
    actValid |-> !rowOpen);

endmodule

bind bankWriteSeq bws_checker #(.TW(TW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .busy     (busy),
  .actValid (actValid),
  .wrValid  (wrValid),
  .retValid (retValid),
  .mskValid (mskValid),
  .preValid (preValid),
  .cfgRas   (cfgRas)
);

// File: tb/tb_bankWriteSeq.sv
`timescale 1ns/1ps
module tb_bankWriteSeq;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid;
  logic         reqReady;
  logic [4:0]   reqDev;
  logic [3:0]   reqBank;
  logic [8:0]   reqRow;
  logic [3:0]   reqColCount;
  logic [47:0]  reqColList;
  logic [7:0]   reqMaskUse;
  logic [127:0] reqMaskList;
  logic [7:0]   cfgRcd, cfgCwd, cfgCc, cfgRtr, cfgRas, cfgRtp, cfgRc, cfgRp;
  logic         busy;
  logic [4:0]   cmdDev;
  logic [3:0]   cmdBank;
  logic         actValid;
  logic [8:0]   actRow;
  logic         wrValid;
  logic [5:0]   wrCol;
  logic         retValid;
  logic         mskValid;
  logic [15:0]  mskBits;
  logic         wdValid;
  logic [2:0]   wdIndex;
  logic         preValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bankWriteSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDev(reqDev), .reqBank(reqBank), .reqRow(reqRow),
    .reqColCount(reqColCount), .reqColList(reqColList),
    .reqMaskUse(reqMaskUse), .reqMaskList(reqMaskList),
    .cfgRcd(cfgRcd), .cfgCwd(cfgCwd), .cfgCc(cfgCc), .cfgRtr(cfgRtr),
    .cfgRas(cfgRas), .cfgRtp(cfgRtp), .cfgRc(cfgRc), .cfgRp(cfgRp),
    .busy(busy), .cmdDev(cmdDev), .cmdBank(cmdBank),
    .actValid(actValid), .actRow(actRow), .wrValid(wrValid), .wrCol(wrCol),
    .retValid(retValid), .mskValid(mskValid), .mskBits(mskBits),
    .wdValid(wdValid), .wdIndex(wdIndex), .preValid(preValid)
  );

  task automatic chk(input string tag, input string what,
                     input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int colOf(input int seed, input int k);
    return (seed * 7 + k * 5 + 3) & 63;
  endfunction

  function automatic int maskOf(input int seed, input int k);
    return (16'hA5A5 ^ (k * 4369 + seed * 13)) & 16'hFFFF;
  endfunction

  // index k of a periodic event (base + k*step, k < n) at cycle r, else -1
  function automatic int evIdx(input int r, input int base, input int step, input int n);
    if (r < base) return -1;
    if (((r - base) % step) != 0) return -1;
    if (((r - base) / step) >= n) return -1;
    return (r - base) / step;
  endfunction

  task automatic idleCheck(input string tag);
    chk(tag, "ready idle", reqReady, 1);
    chk(tag, "busy idle", busy, 0);
    chk(tag, "act idle", actValid, 0);
    chk(tag, "wr idle", wrValid, 0);
    chk(tag, "ret idle", retValid, 0);
    chk(tag, "msk idle", mskValid, 0);
    chk(tag, "wd idle", wdValid, 0);
    chk(tag, "pre idle", preValid, 0);
  endtask

  // Called at a falling edge; returns at the falling edge of cycle E-1.
  task automatic runTxn(input int t[8], input int cnt, input int seed,
                        input bit stream, input bit scramble, input string ctx);
    int n, rcd, cwd, cc, rtr, ras, rtp, rc, rp, pCyc, dLast, eCyc, kw, kd, kr;
    logic [7:0] useBits;
    n   = (cnt == 0) ? 1 : ((cnt > 8) ? 8 : cnt);
    rcd = eff(t[0]); cwd = eff(t[1]); cc  = eff(t[2]); rtr = eff(t[3]);
    ras = eff(t[4]); rtp = eff(t[5]); rc  = eff(t[6]); rp  = eff(t[7]);
    useBits = 8'(seed * 29 + 85);

    reqDev      = 5'(seed * 3 + 1);
    reqBank     = 4'(seed + 2);
    reqRow      = 9'(seed * 37 + 11);
    reqColCount = 4'(cnt);
    for (int k = 0; k < 8; k++) begin
      reqColList[k*6 +: 6]    = 6'(colOf(seed, k));
      reqMaskList[k*16 +: 16] = 16'(maskOf(seed, k));
    end
    reqMaskUse = useBits;
    cfgRcd = 8'(t[0]); cfgCwd = 8'(t[1]); cfgCc  = 8'(t[2]); cfgRtr = 8'(t[3]);
    cfgRas = 8'(t[4]); cfgRtp = 8'(t[5]); cfgRc  = 8'(t[6]); cfgRp  = 8'(t[7]);
    reqValid = 1'b1;
    chk("R7", {"ready before accept ", ctx}, reqReady, 1);

    @(posedge clk);
    @(negedge clk);
    if (!stream) reqValid = 1'b0;
    if (scramble) begin  // R10: must not alter the running schedule
      cfgRcd = 8'd250; cfgCwd = 8'd250; cfgCc = 8'd250; cfgRtr = 8'd250;
      cfgRas = 8'd250; cfgRtp = 8'd250; cfgRc = 8'd250; cfgRp = 8'd250;
    end

    pCyc  = maxi(ras, rcd + (n - 1) * cc + rtr + rtp);
    dLast = rcd + (n - 1) * cc + cwd + 1;
    eCyc  = maxi(maxi(rc, pCyc + rp), dLast + 1);

    for (int r = 0; r < eCyc; r++) begin
      if (r > 0) @(negedge clk);
      kw = evIdx(r, rcd, cc, n);
      kd = evIdx(r, rcd + cwd + 1, cc, n);
      kr = evIdx(r, rcd + rtr, cc, n);

      chk("R2", {"activate ", ctx}, actValid, (r == 0));
      if (r == 0) begin
        chk("R2", {"activate row ", ctx}, actRow, (seed * 37 + 11) & 511);
        chk("R2", {"device ", ctx}, cmdDev, (seed * 3 + 1) & 31);
        chk("R2", {"bank ", ctx}, cmdBank, (seed + 2) & 15);
      end
      chk("R3", {"write strobe ", ctx}, wrValid, (kw >= 0));
      if (kw >= 0) chk("R3", {"write column ", ctx}, wrCol, colOf(seed, kw));
      chk("R4", {"data strobe ", ctx}, wdValid, (kd >= 0));
      if (kd >= 0) chk("R4", {"data index ", ctx}, wdIndex, kd);
      chk("R5", {"retire strobe ", ctx}, retValid, (kr >= 0));
      chk("R5", {"mask strobe ", ctx}, mskValid, (kr >= 0) && useBits[kr & 7]);
      if (kr >= 0 && useBits[kr & 7])
        chk("R5", {"mask bits ", ctx}, mskBits, maskOf(seed, kr));
      chk("R6", {"precharge ", ctx}, preValid, (r == pCyc));
      if (r == pCyc) chk("R6", {"precharge bank ", ctx}, cmdBank, (seed + 2) & 15);
      chk("R7", {"ready ", ctx}, reqReady, (r == eCyc - 1));
      chk("R7", {"busy ", ctx}, busy, (r != eCyc - 1));
    end
  endtask

  int tset [6][8] = '{
    '{3, 2, 2, 4, 10, 2, 14, 3},
    '{1, 1, 1, 1, 1, 1, 1, 1},
    '{0, 0, 0, 0, 0, 0, 0, 0},    // R9 zero-as-one set
    '{5, 6, 4, 3, 30, 3, 40, 4},
    '{2, 8, 3, 7, 4, 5, 6, 9},
    '{4, 20, 1, 2, 3, 1, 5, 1}
  };

  initial begin
    rstN = 1'b0; reqValid = 1'b0;
    reqDev = '0; reqBank = '0; reqRow = '0; reqColCount = '0;
    reqColList = '0; reqMaskUse = '0; reqMaskList = '0;
    cfgRcd = '0; cfgCwd = '0; cfgCc = '0; cfgRtr = '0;
    cfgRas = '0; cfgRtp = '0; cfgRc = '0; cfgRp = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    idleCheck("R1");
    rstN = 1'b1;
    @(negedge clk);
    idleCheck("R1");

    // sweep: every timing set against every column count
    for (int s = 0; s < 6; s++)
      for (int n = 1; n <= 8; n++)
        runTxn(tset[s], n, s * 8 + n, 1'b0, 1'b0, (s == 2) ? "R9 sweep" : "sweep");

    // R8 clamping of the column count
    runTxn(tset[0], 0, 60, 1'b0, 1'b0, "R8 count zero");
    runTxn(tset[3], 12, 61, 1'b0, 1'b0, "R8 count high");

    // R7 request held valid through busy is not taken early
    runTxn(tset[3], 3, 62, 1'b1, 1'b0, "R7 held");
    runTxn(tset[3], 3, 62, 1'b1, 1'b0, "R7 held");
    runTxn(tset[3], 3, 62, 1'b0, 1'b0, "R7 held");

    // R10 timing registers rewritten mid-transaction
    runTxn(tset[4], 5, 63, 1'b0, 1'b1, "R10 rewrite");
    runTxn(tset[0], 2, 64, 1'b0, 1'b1, "R10 rewrite");

    reqValid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      idleCheck("R11 quiet");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule